// File: doc/BRIEF.md
# Group change-of-state interrupt controller

This block watches 48 digital input lines, arranged as six 8-bit groups, and raises a single interrupt request when any line in an enabled group changes level in either direction. A host reaches it through a small 8-bit peripheral port. That port has a 3-bit byte address, read and write strobes, write data and combinational read data.

Six byte offsets return the synchronised level of each group. One offset is left empty. The top offset has two roles. A write there loads the per-group enable mask. A read there returns the latched per-group change flags and an active-low pending bit, and it also acknowledges the interrupt. Masking of individual lines inside a group is left to host software.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset the enable mask is zero, no group flag is set, `irq_o` is low, and a read of offset 7 returns 0x40.
- R2: Each line passes through two synchroniser flops. Group g (line g*8+n sits in bit n) reads back at offset 0, 1, 2, 4, 5 or 6 for g = 0..5, in that order.
- R3: A read of offset 3 returns 0x00, and bit 7 of a status read (offset 7) is always 0.
- R4: A write to offset 7 loads bits 5:0 of the write data as the enable mask, where bit g enables group g. Writing 0 disables every group.
- R5: A rising or a falling level change on any line of an enabled group sets status bit g and drives `irq_o` high. Status bit 6 reads 0 while any flag is set and 1 otherwise.
- R6: Level changes in a group whose enable bit is 0 never set that group's flag and never raise `irq_o`.
- R7: A read of offset 7 clears all group flags at that clock edge. After the edge, bit 6 reads 1 and `irq_o` is low.
- R8: A change that reaches the detector in the same cycle as an acknowledging read stays latched and is reported by the next status read.
- R9: Clearing a group's enable bit clears that group's pending flag at the same clock edge as the write.
- R10: Writes to offsets 0 through 6 have no effect on the enable mask or on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lines_i | input | 48 | Asynchronous input lines |
| addr_i | input | 3 | Byte offset within the 8-byte window |
| rd_i | input | 1 | Read strobe, one cycle |
| wr_i | input | 1 | Write strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is a new change that reaches the edge detector in exactly the cycle whose clock edge performs the acknowledging read. That timing depends on the synchroniser depth. The bench toggles a line on a falling clock edge and then counts two more falling edges before it raises the read strobe. This places the detector pulse on the acknowledge edge. The bench then expects the old flags from that read and the new group's flag from the next one. Disable-while-pending is reached in a similar way: the bench leaves a flag latched and then writes a mask without that group.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int          ADDR_W   = 3;
  localparam int          DATA_W   = 8;
  localparam int          HOLE_IDX = 3;
  localparam logic [2:0]  STAT_OFF = 3'd7;
  localparam logic [2:0]  HOLE_OFF = 3'd3;

  // byte offset of a group: offsets below the hole map 1:1, the rest shift up
  function automatic logic [ADDR_W-1:0] grp_off(input int g);
    return (g < HOLE_IDX) ? ADDR_W'(g) : ADDR_W'(g + 1);
  endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cos_grp_det.sv
module cos_grp_det #(
  parameter int GRP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GRP_W-1:0] smp_i,
  input  logic             en_i,
  input  logic             ack_i,
  output logic             edge_o,
  output logic             flag_o
);
  logic [GRP_W-1:0] prev_q;
  logic             flag_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= smp_i;

  assign edge_o = |(smp_i ^ prev_q);

  // en_i is the post-write enable, so disabling clears the flag on the write edge
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= en_i & ((flag_q & ~ack_i) | edge_o);

  assign flag_o = flag_q;
endmodule

// File: rtl/cos_rd_mux.sv
module cos_rd_mux
  import cos_pkg::*;
#(
  parameter int NUM_GRP = 6,
  parameter int GRP_W   = 8
) (
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NUM_GRP*GRP_W-1:0] smp_i,
  input  logic [NUM_GRP-1:0]       flags_i,
  input  logic                     pend_i,
  output logic [DATA_W-1:0]        rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (addr_i == STAT_OFF) begin
      rdata_o[NUM_GRP-1:0] = flags_i;
      rdata_o[NUM_GRP]     = ~pend_i;
    end else begin
      for (int g = 0; g < NUM_GRP; g++)
        if (addr_i == grp_off(g)) rdata_o[GRP_W-1:0] = smp_i[g*GRP_W +: GRP_W];
    end
  end
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int NUM_GRP     = 6,
  parameter int GRP_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_GRP*GRP_W-1:0] lines_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     rd_i,
  input  logic                     wr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     irq_o
);
  localparam int N_LINES = NUM_GRP * GRP_W;

  logic [N_LINES-1:0] smp;
  logic [NUM_GRP-1:0] en_q, en_d, flags, grp_edge;
  logic               wr_en, ack;

  cos_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lines_i),
    .q_o   (smp)
  );

  assign wr_en = wr_i && (addr_i == STAT_OFF);
  assign ack   = rd_i && (addr_i == STAT_OFF);
  assign en_d  = wr_en ? wdata_i[NUM_GRP-1:0] : en_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    cos_grp_det #(.GRP_W(GRP_W)) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .smp_i (smp[g*GRP_W +: GRP_W]),
      .en_i  (en_d[g]),
      .ack_i (ack),
      .edge_o(grp_edge[g]),
      .flag_o(flags[g])
    );
  end

  assign irq_o = |flags;

  cos_rd_mux #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_rd (
    .addr_i (addr_i),
    .smp_i  (smp),
    .flags_i(flags),
    .pend_i (irq_o),
    .rdata_o(rdata_o)
  );
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk
  import cos_pkg::*;
#(
  parameter int NUM_GRP = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               rd_i,
  input logic               wr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               irq_o,
  input logic [NUM_GRP-1:0] flags_i,
  input logic [NUM_GRP-1:0] en_i,
  input logic [NUM_GRP-1:0] edge_i
);
  a_r5_pend_bit_tracks_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == STAT_OFF) |-> (rdata_o[NUM_GRP] == !irq_o));

  a_r3_hole_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == HOLE_OFF) |-> (rdata_o == '0));

  a_r3_stat_bit7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == STAT_OFF) |-> !rdata_o[7]);

  a_r6_flags_within_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i & ~en_i) == '0);

  a_r7_ack_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == STAT_OFF && edge_i == '0) |=> !irq_o);

  a_r8_edge_on_ack_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && addr_i == STAT_OFF && |(edge_i & en_i)) |=> irq_o);

  a_r9_disable_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == STAT_OFF) |=> ((flags_i & ~$past(wdata_i[NUM_GRP-1:0])) == '0));
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.NUM_GRP(NUM_GRP)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .addr_i (addr_i),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_o  (irq_o),
  .flags_i(flags),
  .en_i   (en_q),
  .edge_i (grp_edge)
);

// File: tb/sim_cos_irq_ctrl.sv
`timescale 1ns/1ps
module sim_cos_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] lines = '0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  cos_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: push expectation, strobe read for one cycle
  task automatic do_read(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    addr <= a; rd <= 1'b1;
    @(negedge clk);
    rd <= 1'b0;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr <= a; wdata <= d; wr <= 1'b1;
    @(negedge clk);
    wr <= 1'b0;
  endtask

  task automatic flip(input int idx);
    @(negedge clk);
    lines[idx] = ~lines[idx];
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk);
    #2 chk(tag, {7'b0, irq}, {7'b0, exp});
  endtask

  // monitor: compare reads mid-cycle while the strobe is high
  initial forever begin
    @(negedge clk);
    #2;
    if (rd) begin
      if (exp_q.size() == 0) chk("monitor_underflow", 8'h00, 8'h01);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_irq("R1 irq after reset", 1'b0);
    do_read(3'd7, 8'h40, "R1 status after reset");
    do_read(3'd3, 8'h00, "R3 offset 3 reads zero");

    // R2 group map
    @(negedge clk);
    lines = 48'hA5_3C_F0_0F_81_7E;
    repeat (4) @(negedge clk);
    do_read(3'd0, 8'h7E, "R2 group0 at 0");
    do_read(3'd1, 8'h81, "R2 group1 at 1");
    do_read(3'd2, 8'h0F, "R2 group2 at 2");
    do_read(3'd4, 8'hF0, "R2 group3 at 4");
    do_read(3'd5, 8'h3C, "R2 group4 at 5");
    do_read(3'd6, 8'hA5, "R2 group5 at 6");
    do_read(3'd3, 8'h00, "R3 hole with inputs set");
    do_read(3'd7, 8'h40, "R6 changes with mask zero");

    // R10 writes below offset 7 ignored
    do_write(3'd6, 8'hFF);
    do_write(3'd2, 8'h3F);
    do_read(3'd2, 8'h0F, "R10 group2 unchanged after write");
    flip(44);
    flip(18);
    do_read(3'd7, 8'h40, "R10 no enable from low offsets");

    // R4 enable groups 1,2; R6 group0 ignored
    do_write(3'd7, 8'h06);
    flip(3);
    do_read(3'd7, 8'h40, "R6 disabled group0 ignored");
    chk_irq("R6 irq stays low", 1'b0);

    // R5 rising then falling
    flip(9);
    chk_irq("R5 irq on rising", 1'b1);
    do_read(3'd7, 8'h02, "R5 rising flags group1");
    chk_irq("R7 irq cleared by ack", 1'b0);
    do_read(3'd7, 8'h40, "R7 status after ack");
    flip(9);
    do_read(3'd7, 8'h02, "R5 falling flags group1");

    // R8 change on the acknowledge edge
    flip(12);
    @(negedge clk);
    lines[17] = ~lines[17];
    @(negedge clk);
    do_read(3'd7, 8'h02, "R8 ack read shows old flag");
    chk_irq("R8 irq kept by late edge", 1'b1);
    do_read(3'd7, 8'h04, "R8 late edge reported");
    do_read(3'd7, 8'h40, "R8 clean after second ack");

    // R9 disable clears pending flag
    flip(20);
    chk_irq("R9 pending before disable", 1'b1);
    do_write(3'd7, 8'h02);
    chk_irq("R9 irq dropped by disable", 1'b0);
    do_read(3'd7, 8'h40, "R9 status after disable");
    flip(20);
    do_read(3'd7, 8'h40, "R9 group2 now disabled");

    // R5/R2 edge groups together: line 0 and line 47
    do_write(3'd7, 8'hFF);
    @(negedge clk);
    lines[0] = ~lines[0];
    lines[47] = ~lines[47];
    repeat (4) @(negedge clk);
    do_read(3'd7, 8'h21, "R5 groups 0 and 5 flagged");
    do_read(3'd7, 8'h40, "R7 both cleared");

    // R4 write zero disables all
    do_write(3'd7, 8'h00);
    flip(40);
    flip(7);
    chk_irq("R4 zero mask no irq", 1'b0);
    do_read(3'd7, 8'h40, "R4 zero mask status");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) chk("R1 scoreboard drained", 8'h00, 8'(exp_q.size()));
    finish_run();
  end
endmodule